// File: doc/BRIEF.md
# Planar Frame Buffer Write Datapath

This block sits between a host byte port and a frame buffer organised as four parallel byte planes. For each host write it produces four plane bytes and four plane write strobes in one registered step. The byte is first rotated right. It may then be replaced per plane by a constant fill pattern, or expanded from single host bits. It is then combined with a 32-bit set of read latches through a selectable logical operation. Finally a bit mask merges it with the latched bytes, so that masked positions keep their old contents.

The read latches record the four plane bytes returned by the most recent host read. This is what lets read-modify-write sequences and plane-to-plane copies work without the host seeing all four planes. Address decoding, chained or interleaved addressing and the read-back path are handled elsewhere. All behaviour is set by configuration inputs that are held steady by the surrounding register file.

Top module: `planar_write_path`

## Requirements
- R1: After reset, `wr_strobe` is 0, `wr_data` is 0 and all four read latches hold 0.
- R2: A write request sampled on a clock edge updates `wr_data` and `wr_strobe` right after that edge. After an edge with no write request, `wr_strobe` is 0 and `wr_data` keeps its previous value.
- R3: A read request sampled on an edge loads all four latches at once from `rd_planes`, with plane n taken from bits [8n+7:8n].
- R4: In write mode 0 (`cfg_wmode`=00), the host byte is rotated right by `cfg_rot` positions (bit b of the result is host bit (b+cfg_rot) mod 8) before any other step.
- R5: `cfg_func` chooses how the source byte combines with the plane's latch byte: 00 passes the source unchanged, 01 ANDs, 10 ORs and 11 XORs. This applies in modes 0, 2 and 3.
- R6: In mode 0, a plane n with `cfg_fill_en[n]`=1 uses eight copies of `cfg_fill[n]` as its source instead of the rotated host byte.
- R7: In mode 1, every plane byte equals that plane's latch byte, whatever the bit mask, the function and the host byte.
- R8: In mode 2, the source of plane n is eight copies of unrotated host bit n, followed by the function and the bit mask.
- R9: In mode 3, every plane uses eight copies of `cfg_fill[n]` whatever `cfg_fill_en`, and the effective mask is the rotated host byte ANDed with `cfg_bitmask`.
- R10: In modes 0, 2 and 3, each output bit whose effective mask bit is 0 equals the corresponding latch bit, and each bit whose mask bit is 1 takes the computed bit.
- R11: On a write, `wr_strobe` equals `cfg_plane_we`. All four data bytes are still updated.
- R12: When a read and a write are requested on the same edge, the write uses the latch contents from before that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wdata | input | 8 | Host write byte |
| wr_req | input | 1 | Host write request |
| rd_req | input | 1 | Host read request; loads the latches |
| rd_planes | input | 32 | Four plane bytes being read, plane n at [8n+7:8n] |
| cfg_fill | input | 4 | Per-plane fill bit |
| cfg_fill_en | input | 4 | Per-plane fill enable (mode 0) |
| cfg_rot | input | 3 | Right-rotate amount |
| cfg_func | input | 2 | Logical operation with latches |
| cfg_wmode | input | 2 | Write mode 0..3 |
| cfg_bitmask | input | 8 | Bit protection mask, 1 = writable |
| cfg_plane_we | input | 4 | Plane write enable mask |
| wr_data | output | 32 | Registered plane write bytes |
| wr_strobe | output | 4 | Registered plane write strobes |

## Verification
The hardest case to reach is a read and a write on the same edge (R12). There the output must come from the old latch contents while the latches take new bytes. The bench drives both requests in one cycle with a latch pattern that differs from every earlier one. It then uses a mode 1 write to bring the new latch contents out to `wr_data`. The main sweep covers every combination of mode, function and rotate amount over several host bytes and fill-enable patterns. Between groups of writes it reloads the latches with fresh patterns so that the latch bits and the mask bits both vary.

// File: rtl/pwd_pkg.sv
package pwd_pkg;

   typedef enum logic [1:0] {
      WM_DIRECT = 2'd0,
      WM_LATCH  = 2'd1,
      WM_EXPAND = 2'd2,
      WM_MASKED = 2'd3
   } wmode_e;

   typedef enum logic [1:0] {
      OP_PASS = 2'd0,
      OP_AND  = 2'd1,
      OP_OR   = 2'd2,
      OP_XOR  = 2'd3
   } op_e;

endpackage

// File: rtl/pwd_rotator.sv
module pwd_rotator #(
   parameter int W  = 8,
   parameter int CW = $clog2(W)
) (
   input  logic [W-1:0]  din,
   input  logic [CW-1:0] amt,
   output logic [W-1:0]  dout
);
   localparam int DW = 2 * W;

   logic [DW-1:0] doubled;

   // rotate right by shifting a doubled copy
   assign doubled = {din, din} >> amt;
   assign dout    = doubled[W-1:0];
endmodule

// File: rtl/pwd_latch_bank.sv
module pwd_latch_bank #(
   parameter int P = 4,
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [P*W-1:0] din,
   output logic [P*W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= din;
   end

   // R3: all planes captured together on a read
   a_r3_latch_capture: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (q == $past(din)));

   a_r3_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(q));
endmodule

// File: rtl/pwd_lane.sv
module pwd_lane #(
   parameter int W = 8
) (
   input  logic [W-1:0] host_rot,
   input  logic         host_bit,
   input  logic         fill_bit,
   input  logic         fill_en,
   input  logic [1:0]   mode,
   input  logic [1:0]   op,
   input  logic [W-1:0] bitmask,
   input  logic [W-1:0] latch,
   output logic [W-1:0] result
);
   import pwd_pkg::*;

   wmode_e      m;
   op_e         o;
   logic [W-1:0] src;
   logic [W-1:0] msk;
   logic [W-1:0] alu;

   assign m = wmode_e'(mode);
   assign o = op_e'(op);

   always_comb begin
      src = host_rot;
      msk = bitmask;
      unique case (m)
         WM_DIRECT: src = fill_en ? {W{fill_bit}} : host_rot;
         WM_EXPAND: src = {W{host_bit}};
         WM_MASKED: begin
            src = {W{fill_bit}};
            msk = host_rot & bitmask;
         end
         default: ;
      endcase

      unique case (o)
         OP_AND:  alu = src & latch;
         OP_OR:   alu = src | latch;
         OP_XOR:  alu = src ^ latch;
         default: alu = src;
      endcase

      if (m == WM_LATCH) result = latch;
      else               result = (alu & msk) | (latch & ~msk);
   end
endmodule

// File: rtl/planar_write_path.sv
module planar_write_path #(
   parameter int PLANES = 4,
   parameter int LANE_W = 8,
   localparam int ROT_W = $clog2(LANE_W),
   localparam int BUS_W = PLANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LANE_W-1:0] host_wdata,
   input  logic              wr_req,
   input  logic              rd_req,
   input  logic [BUS_W-1:0]  rd_planes,
   input  logic [PLANES-1:0] cfg_fill,
   input  logic [PLANES-1:0] cfg_fill_en,
   input  logic [ROT_W-1:0]  cfg_rot,
   input  logic [1:0]        cfg_func,
   input  logic [1:0]        cfg_wmode,
   input  logic [LANE_W-1:0] cfg_bitmask,
   input  logic [PLANES-1:0] cfg_plane_we,
   output logic [BUS_W-1:0]  wr_data,
   output logic [PLANES-1:0] wr_strobe
);
   import pwd_pkg::*;

   // elaboration-time parameter checks
   if (LANE_W < 2 || (LANE_W & (LANE_W - 1)) != 0) begin : g_bad_lane
      $error("LANE_W must be a power of two of at least 2");
   end
   if (PLANES < 1 || PLANES > LANE_W) begin : g_bad_planes
      $error("PLANES must lie between 1 and LANE_W");
   end

   logic [BUS_W-1:0]  latch_q;
   logic [LANE_W-1:0] host_rot;
   logic [BUS_W-1:0]  next_data;

   pwd_rotator #(.W(LANE_W), .CW(ROT_W)) u_rot (
      .din  (host_wdata),
      .amt  (cfg_rot),
      .dout (host_rot)
   );

   pwd_latch_bank #(.P(PLANES), .W(LANE_W)) u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (rd_req),
      .din   (rd_planes),
      .q     (latch_q)
   );

   for (genvar p = 0; p < PLANES; p++) begin : g_lane
      pwd_lane #(.W(LANE_W)) u_lane (
         .host_rot (host_rot),
         .host_bit (host_wdata[p]),
         .fill_bit (cfg_fill[p]),
         .fill_en  (cfg_fill_en[p]),
         .mode     (cfg_wmode),
         .op       (cfg_func),
         .bitmask  (cfg_bitmask),
         .latch    (latch_q[p*LANE_W +: LANE_W]),
         .result   (next_data[p*LANE_W +: LANE_W])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_data   <= '0;
         wr_strobe <= '0;
      end else begin
         wr_strobe <= wr_req ? cfg_plane_we : '0;
         if (wr_req) wr_data <= next_data;
      end
   end

   // R2: strobes drop and data holds without a request
   a_r2_idle_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_req |=> (wr_strobe == '0));
   a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_req |=> $stable(wr_data));
   // R11: strobe follows plane enable mask
   a_r11_strobe_gate: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |=> (wr_strobe == $past(cfg_plane_we)));
   // R7: latch copy mode (also R12: pre-read latch contents)
   a_r7_latch_copy: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && cfg_wmode == 2'd1) |=> (wr_data == $past(latch_q)));
   // R10: protected bits keep latch value in mode 0 and mode 2
   a_r10_mask_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !cfg_wmode[0]) |=>
         (((wr_data ^ $past(latch_q)) & ~{PLANES{$past(cfg_bitmask)}}) == '0));
endmodule

// File: tb/tb_planar_write_path.sv
module tb_planar_write_path;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [7:0]  host_wdata;
   logic        wr_req, rd_req;
   logic [31:0] rd_planes;
   logic [3:0]  cfg_fill, cfg_fill_en, cfg_plane_we;
   logic [2:0]  cfg_rot;
   logic [1:0]  cfg_func, cfg_wmode;
   logic [7:0]  cfg_bitmask;
   logic [31:0] wr_data;
   logic [3:0]  wr_strobe;

   int checks = 0;
   int failures = 0;
   bit done = 0;
   logic [31:0] exp_lat = '0;

   always #2 clk = ~clk;

   planar_write_path dut (
      .clk(clk), .rst_n(rst_n), .host_wdata(host_wdata), .wr_req(wr_req),
      .rd_req(rd_req), .rd_planes(rd_planes), .cfg_fill(cfg_fill),
      .cfg_fill_en(cfg_fill_en), .cfg_rot(cfg_rot), .cfg_func(cfg_func),
      .cfg_wmode(cfg_wmode), .cfg_bitmask(cfg_bitmask),
      .cfg_plane_we(cfg_plane_we), .wr_data(wr_data), .wr_strobe(wr_strobe)
   );

   // bitwise model built from the requirement text
   function automatic logic [31:0] model(input logic [7:0] h, input logic [1:0] md,
         input logic [1:0] fn, input logic [2:0] rt, input logic [3:0] fl,
         input logic [3:0] fe, input logic [7:0] bm, input logic [31:0] lat);
      logic [31:0] r;
      r = '0;
      for (int p = 0; p < 4; p++) begin
         for (int b = 0; b < 8; b++) begin
            logic hr, s, l, a, mk;
            hr = h[(b + rt) % 8];
            l  = lat[p*8 + b];
            mk = bm[b];
            case (md)
               2'd0: s = fe[p] ? fl[p] : hr;
               2'd2: s = h[p];
               default: begin s = fl[p]; mk = bm[b] & hr; end
            endcase
            case (fn)
               2'd1: a = s & l;
               2'd2: a = s | l;
               2'd3: a = s ^ l;
               default: a = s;
            endcase
            if (md == 2'd1) r[p*8 + b] = l;
            else            r[p*8 + b] = mk ? a : l;
         end
      end
      return r;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_read(input logic [31:0] v);
      @(negedge clk);
      rd_req = 1'b1; rd_planes = v;
      @(negedge clk);
      rd_req = 1'b0;
      exp_lat = v;
   endtask

   // write with current config, check data and strobe one cycle later
   task automatic do_write(input string tag, input logic [7:0] h);
      logic [31:0] e;
      @(negedge clk);
      host_wdata = h; wr_req = 1'b1;
      e = model(h, cfg_wmode, cfg_func, cfg_rot, cfg_fill, cfg_fill_en, cfg_bitmask, exp_lat);
      @(negedge clk);
      wr_req = 1'b0;
      chk(tag, wr_data, e);
      chk({tag, " strobe"}, {28'd0, wr_strobe}, {28'd0, cfg_plane_we});
   endtask

   initial begin
      #800000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [7:0] hosts [4];
      logic [3:0] fens [4];
      logic [31:0] old;
      int n;
      hosts[0] = 8'h96; hosts[1] = 8'h01; hosts[2] = 8'hF3; hosts[3] = 8'h5C;
      fens[0] = 4'h0; fens[1] = 4'hF; fens[2] = 4'h5; fens[3] = 4'hA;
      rst_n = 1'b0; wr_req = 0; rd_req = 0; rd_planes = '0; host_wdata = '0;
      cfg_fill = '0; cfg_fill_en = '0; cfg_rot = '0; cfg_func = '0;
      cfg_wmode = '0; cfg_bitmask = 8'hFF; cfg_plane_we = 4'hF;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 data", wr_data, 32'h0);
      chk("R1 strobe", {28'd0, wr_strobe}, 32'h0);
      rst_n = 1'b1;
      cfg_wmode = 2'd1;
      do_write("R1 latches zero", 8'hFF);

      // R3: latch load, brought out by mode 1
      do_read(32'hA1B2C3D4);
      cfg_bitmask = 8'h00; cfg_func = 2'd3;
      do_write("R3 latch load", 8'h55);

      // R2: idle cycle -> strobe low, data held
      old = wr_data;
      @(negedge clk);
      chk("R2 idle strobe", {28'd0, wr_strobe}, 32'h0);
      chk("R2 idle hold", wr_data, old);

      // R5: each function, mode 0, no rotation, full mask
      cfg_wmode = 2'd0; cfg_rot = 3'd0; cfg_bitmask = 8'hFF; cfg_fill_en = 4'h0;
      do_read(32'hF0CC33AA);
      for (int f = 0; f < 4; f++) begin
         cfg_func = 2'(f);
         do_write("R5 function", 8'h3C);
      end

      // R6: fill on planes 0 and 2
      cfg_func = 2'd0; cfg_fill_en = 4'b0101; cfg_fill = 4'b0001;
      do_write("R6 fill", 8'h81);
      chk("R6 plane0 ones", {24'd0, wr_data[7:0]}, 32'hFF);
      chk("R6 plane2 zeros", {24'd0, wr_data[23:16]}, 32'h00);

      // R10: all bits protected -> latch returned
      cfg_bitmask = 8'h00; cfg_func = 2'd3;
      do_write("R10 full protect", 8'h77);
      chk("R10 equals latch", wr_data, 32'hF0CC33AA);

      // R11: partial plane enable
      cfg_plane_we = 4'b1010; cfg_bitmask = 8'hFF;
      do_write("R11 plane enable", 8'h42);
      @(negedge clk);
      chk("R11 strobe drops", {28'd0, wr_strobe}, 32'h0);
      cfg_plane_we = 4'hF;

      // R12: read and write on the same edge
      cfg_wmode = 2'd0; cfg_func = 2'd2; cfg_fill_en = 4'h0; cfg_rot = 3'd3;
      cfg_bitmask = 8'h5A;
      @(negedge clk);
      host_wdata = 8'h19; wr_req = 1'b1; rd_req = 1'b1; rd_planes = 32'h0F1E2D3C;
      old = model(8'h19, 2'd0, 2'd2, 3'd3, cfg_fill, 4'h0, 8'h5A, exp_lat);
      @(negedge clk);
      wr_req = 1'b0; rd_req = 1'b0;
      chk("R12 old latches used", wr_data, old);
      exp_lat = 32'h0F1E2D3C;
      cfg_wmode = 2'd1;
      do_write("R12 new latches loaded", 8'h00);

      // sweep: every mode, function and rotation (R4 R7 R8 R9)
      n = 0;
      for (int m = 0; m < 4; m++)
         for (int f = 0; f < 4; f++)
            for (int r = 0; r < 8; r++)
               for (int hv = 0; hv < 4; hv++)
                  for (int fe = 0; fe < 4; fe++) begin
                     string tag;
                     if (n % 64 == 0)
                        do_read(32'(n) * 32'h9E3779B1 ^ 32'h6C8E9CF5);
                     n++;
                     cfg_wmode = 2'(m); cfg_func = 2'(f); cfg_rot = 3'(r);
                     cfg_fill_en = fens[fe]; cfg_fill = 4'(hv * 5 + fe);
                     cfg_bitmask = 8'(r * 37 + f * 11 + hv * 53 + fe);
                     cfg_plane_we = 4'(f * 4 + r);
                     case (m)
                        0: tag = "R4 mode0 rotate";
                        1: tag = "R7 mode1 copy";
                        2: tag = "R8 mode2 expand";
                        default: tag = "R9 mode3 masked";
                     endcase
                     do_write(tag, hosts[hv] ^ 8'(n));
                  end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule